// File: doc/BRIEF.md
# Stack Pointer Register Unit

This block keeps the 11-bit stack pointer of a small 8-bit processor core. Software sees the pointer as two byte-wide registers on a plain register bus. The bus decodes each register at its I/O address and at the data-space alias of that address. The core moves the pointer with four single-cycle command strobes: byte push, byte pop, return-address push (call or interrupt entry) and return-address pop (return or return-from-interrupt). Byte operations step the pointer by one. Return-address operations step it by two.

Alongside the pointer, the block gives the data-memory port the addresses for the current stack access. It uses a post-decrement push and a pre-increment pop. For a two-byte access, one address carries the low return-address byte and the other carries the high byte, and the low byte sits at the higher address. The strobes and the error flag are plain control pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. The core must not issue more than one strobe per cycle. Software places the stack above data address 0x60, below the top of the 0x460-location memory.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer is 0, and both pointer registers read 0x00.
- R2: A bus write to address 0x3D or 0x5D loads pointer bits 7..0 from the write data. Reading either address returns those bits.
- R3: A bus write to address 0x3E or 0x5E loads pointer bits 10..8 from write-data bits 2..0. Write-data bits 7..3 are ignored. A read returns pointer bits 10..8 in bits 2..0, and bits 7..3 read as 0.
- R4: A byte-push strobe lowers the pointer by 1, and a byte-pop strobe raises it by 1.
- R5: A call strobe lowers the pointer by 2, and a return strobe raises it by 2.
- R6: All pointer arithmetic wraps modulo 2048. A push at 0 gives 2047, and a return at 2047 gives 1.
- R7: If a bus write to a pointer register and a strobe fall in the same cycle, only the bus write takes effect.
- R8: If two or more strobes are high in one cycle, `cmd_err` is 1 in that cycle and the pointer is unchanged. Otherwise `cmd_err` is 0.
- R9: Access addresses depend on the strobe, with SP the current pointer:
  - push: `acc_addr_a` = SP.
  - pop: `acc_addr_a` = SP+1.
  - call: `acc_addr_a` = SP (low byte) and `acc_addr_b` = SP-1 (high byte).
  - return: `acc_addr_a` = SP+2 (low byte) and `acc_addr_b` = SP+1 (high byte).
  - For push, pop, no strobe or an error, `acc_addr_b` equals `acc_addr_a`, and with no strobe or an error both equal SP.
- R10: Bus accesses to any other address read 0x00 and leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Register bus address (I/O or data-space alias) |
| bus_wr_en | input | 1 | Register bus write enable |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational on `bus_addr`) |
| cmd_push | input | 1 | Byte push strobe |
| cmd_pop | input | 1 | Byte pop strobe |
| cmd_call | input | 1 | Return-address push strobe |
| cmd_ret | input | 1 | Return-address pop strobe |
| cmd_err | output | 1 | More than one strobe is active this cycle |
| sp_out | output | 11 | Current stack pointer |
| acc_addr_a | output | 11 | Stack access address (single byte or low return byte) |
| acc_addr_b | output | 11 | Stack access address of the high return byte |

## Verification
The bench builds the block with its default 11-bit pointer. That width is small enough to load every one of the 2048 pointer values through the bus, alternating between the I/O addresses and the data-space aliases. At each value it runs push, pop, call and return, and checks the access addresses and results against modular arithmetic. The sweep therefore reaches both wrap points. Separate cases cover the masked high bits, strobe collisions, bus-over-strobe precedence and unmapped addresses.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    SP_OP_NONE,
    SP_OP_PUSH,
    SP_OP_POP,
    SP_OP_CALL,
    SP_OP_RET
  } sp_op_e;
endpackage

// File: rtl/sp_cmd_decode.sv
module sp_cmd_decode
  import sp_pkg::*;
(
  input  logic   push_i,
  input  logic   pop_i,
  input  logic   call_i,
  input  logic   ret_i,
  output sp_op_e op_o,
  output logic   multi_o
);
  localparam int N_CMD = 4;
  logic [N_CMD-1:0] vec;
  logic [2:0]       cnt;

  assign vec = {ret_i, call_i, pop_i, push_i};

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N_CMD; i++) cnt = cnt + {2'b00, vec[i]};
  end

  assign multi_o = (cnt > 3'd1);

  always_comb begin
    op_o = SP_OP_NONE;
    if (!multi_o) begin
      unique case (1'b1)
        push_i:  op_o = SP_OP_PUSH;
        pop_i:   op_o = SP_OP_POP;
        call_i:  op_o = SP_OP_CALL;
        ret_i:   op_o = SP_OP_RET;
        default: op_o = SP_OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sp_next.sv
module sp_next
  import sp_pkg::*;
#(
  parameter int PTR_W = 11
) (
  input  logic [PTR_W-1:0] sp_i,
  input  sp_op_e           op_i,
  output logic [PTR_W-1:0] nxt_o,
  output logic [PTR_W-1:0] addr_a_o,
  output logic [PTR_W-1:0] addr_b_o
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
  localparam logic [PTR_W-1:0] TWO = PTR_W'(2);

  logic [PTR_W-1:0] dn1, dn2, up1, up2;
  assign dn1 = sp_i - ONE;
  assign dn2 = sp_i - TWO;
  assign up1 = sp_i + ONE;
  assign up2 = sp_i + TWO;

  always_comb begin
    nxt_o    = sp_i;
    addr_a_o = sp_i;
    addr_b_o = sp_i;
    case (op_i)
      SP_OP_PUSH: begin nxt_o = dn1; end
      SP_OP_POP:  begin nxt_o = up1; addr_a_o = up1; addr_b_o = up1; end
      SP_OP_CALL: begin nxt_o = dn2; addr_b_o = dn1; end
      SP_OP_RET:  begin nxt_o = up2; addr_a_o = up2; addr_b_o = up1; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/sp_regbus.sv
module sp_regbus #(
  parameter int             PTR_W    = 11,
  parameter int             BUS_AW   = 7,
  parameter logic [BUS_AW-1:0] LO_IO  = 7'h3D,
  parameter logic [BUS_AW-1:0] HI_IO  = 7'h3E,
  parameter logic [BUS_AW-1:0] ALIAS_OFS = 7'h20
) (
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [PTR_W-1:0]  sp_i,
  output logic              hit_lo_o,
  output logic              hit_hi_o,
  output logic [7:0]        rdata_o
);
  localparam int HI_BITS = PTR_W - 8;
  localparam logic [BUS_AW-1:0] LO_DS = LO_IO + ALIAS_OFS;
  localparam logic [BUS_AW-1:0] HI_DS = HI_IO + ALIAS_OFS;

  assign hit_lo_o = (addr_i == LO_IO) || (addr_i == LO_DS);
  assign hit_hi_o = (addr_i == HI_IO) || (addr_i == HI_DS);

  always_comb begin
    rdata_o = 8'h00;
    if (hit_lo_o)      rdata_o = sp_i[7:0];
    else if (hit_hi_o) rdata_o = {{(8-HI_BITS){1'b0}}, sp_i[PTR_W-1:8]};
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int PTR_W  = 11,
  parameter int BUS_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cmd_push,
  input  logic              cmd_pop,
  input  logic              cmd_call,
  input  logic              cmd_ret,
  output logic              cmd_err,
  output logic [PTR_W-1:0]  sp_out,
  output logic [PTR_W-1:0]  acc_addr_a,
  output logic [PTR_W-1:0]  acc_addr_b
);
  localparam int HI_BITS = PTR_W - 8;

  logic [PTR_W-1:0] sp_q, sp_d, sp_step;
  sp_op_e           op;
  logic             hit_lo, hit_hi, wr_lo, wr_hi;

  sp_cmd_decode u_dec (
    .push_i(cmd_push), .pop_i(cmd_pop), .call_i(cmd_call), .ret_i(cmd_ret),
    .op_o(op), .multi_o(cmd_err)
  );

  sp_next #(.PTR_W(PTR_W)) u_next (
    .sp_i(sp_q), .op_i(op), .nxt_o(sp_step),
    .addr_a_o(acc_addr_a), .addr_b_o(acc_addr_b)
  );

  sp_regbus #(.PTR_W(PTR_W), .BUS_AW(BUS_AW)) u_bus (
    .addr_i(bus_addr), .sp_i(sp_q),
    .hit_lo_o(hit_lo), .hit_hi_o(hit_hi), .rdata_o(bus_rdata)
  );

  assign wr_lo = bus_wr_en && hit_lo;
  assign wr_hi = bus_wr_en && hit_hi;

  always_comb begin
    sp_d = sp_step;
    if (wr_lo || wr_hi) begin
      sp_d = sp_q;
      if (wr_lo) sp_d[7:0]       = bus_wdata;
      if (wr_hi) sp_d[PTR_W-1:8] = bus_wdata[HI_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  assign sp_out = sp_q;

  AST_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> sp_out[7:0] == $past(bus_wdata)); // R2
  AST_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> sp_out[PTR_W-1:8] == $past(bus_wdata[HI_BITS-1:0])); // R3
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_push && !cmd_err && !bus_wr_en) |=> sp_out == $past(sp_out) - PTR_W'(1)); // R4
  AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_call && !cmd_err && !bus_wr_en) |=> sp_out == $past(sp_out) - PTR_W'(2)); // R5
  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err && !(wr_lo || wr_hi)) |=> $stable(sp_out)); // R8
  AST_CALL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_call && !cmd_err) |-> (acc_addr_a == sp_out && acc_addr_b == sp_out - PTR_W'(1))); // R9
  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !hit_lo && !hit_hi && !cmd_push && !cmd_pop && !cmd_call && !cmd_ret)
      |=> $stable(sp_out)); // R10
endmodule

// File: tb/stack_ptr_unit_test.sv
module stack_ptr_unit_test;
  localparam int PW = 11;
  localparam int MASK = (1 << PW) - 1;

  logic clk = 0, rst_n = 0;
  logic [6:0] bus_addr = '0;
  logic bus_wr_en = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic cmd_push = 0, cmd_pop = 0, cmd_call = 0, cmd_ret = 0, cmd_err;
  logic [PW-1:0] sp_out, acc_addr_a, acc_addr_b;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stack_ptr_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_push(cmd_push),
    .cmd_pop(cmd_pop), .cmd_call(cmd_call), .cmd_ret(cmd_ret), .cmd_err(cmd_err),
    .sp_out(sp_out), .acc_addr_a(acc_addr_a), .acc_addr_b(acc_addr_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1;
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic rd_chk(input logic [6:0] a, input int exp, input string req);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic load(input int v, input bit alias_sel);
    bus_wr(alias_sel ? 7'h5D : 7'h3D, v[7:0]);
    bus_wr(alias_sel ? 7'h5E : 7'h3E, {5'b0, v[10:8]});
  endtask

  // s = {push, pop, call, ret}
  task automatic cmd(input logic [3:0] s, input int ea, input int eb,
                     input int eerr, input int esp, input string req);
    @(negedge clk);
    {cmd_push, cmd_pop, cmd_call, cmd_ret} = s;
    #1;
    chk({req, " addr_a"}, acc_addr_a, ea);
    chk({req, " addr_b"}, acc_addr_b, eb);
    chk({req, " err"}, cmd_err, eerr);
    @(negedge clk);
    {cmd_push, cmd_pop, cmd_call, cmd_ret} = '0;
    chk({req, " sp"}, sp_out, esp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sp", sp_out, 0);
    rd_chk(7'h3D, 0, "R1 lo read");
    rd_chk(7'h3E, 0, "R1 hi read");
    rst_n = 1;

    // R3 masked high bits
    bus_wr(7'h3E, 8'hFF);
    chk("R3 sp hi", sp_out, 11'h700);
    rd_chk(7'h5E, 8'h07, "R3 hi read pad zero");
    bus_wr(7'h5E, 8'hF8);
    chk("R3 upper wdata ignored", sp_out, 0);

    // R10 unmapped address
    bus_wr(7'h3D, 8'h5A);
    bus_wr(7'h10, 8'hFF);
    chk("R10 sp unchanged", sp_out, 8'h5A);
    rd_chk(7'h10, 0, "R10 read zero");
    rd_chk(7'h3F, 0, "R10 read zero 3F");

    // R8 multiple strobes
    cmd(4'b1100, 8'h5A, 8'h5A, 1, 8'h5A, "R8 push+pop");
    cmd(4'b0011, 8'h5A, 8'h5A, 1, 8'h5A, "R8 call+ret");
    cmd(4'b1111, 8'h5A, 8'h5A, 1, 8'h5A, "R8 all");
    cmd(4'b0000, 8'h5A, 8'h5A, 0, 8'h5A, "R9 idle");

    // R7 bus write wins over strobe
    @(negedge clk);
    bus_addr = 7'h3D; bus_wdata = 8'h33; bus_wr_en = 1; cmd_call = 1;
    @(negedge clk);
    bus_wr_en = 0; cmd_call = 0;
    chk("R7 write beats call", sp_out, 8'h33);
    @(negedge clk);
    bus_addr = 7'h5E; bus_wdata = 8'h02; bus_wr_en = 1; cmd_pop = 1;
    @(negedge clk);
    bus_wr_en = 0; cmd_pop = 0;
    chk("R7 write beats pop", sp_out, 11'h233);

    // Exhaustive sweep R2 R4 R5 R6 R9
    for (int v = 0; v <= MASK; v++) begin
      load(v, v[0]);
      chk("R2 R3 load", sp_out, v);
      rd_chk(v[0] ? 7'h3D : 7'h5D, v & 8'hFF, "R2 lo read");
      rd_chk(v[0] ? 7'h3E : 7'h5E, v >> 8, "R3 hi read");
      cmd(4'b1000, v, v, 0, (v - 1) & MASK, "R4 R6 push");
      cmd(4'b0100, v, v, 0, v, "R4 R9 pop");
      cmd(4'b0010, v, (v - 1) & MASK, 0, (v - 2) & MASK, "R5 R6 call");
      cmd(4'b0001, v, (v - 1) & MASK, 0, v, "R5 R9 ret");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule